// File: doc/BRIEF.md
# Chained FIFO Slice Token Controller

This block is the control side of a group of identical FIFO slices. It can run the slices as independent buffers, or join them into one deeper buffer. Each slice has a write address counter, a read address counter and an occupancy count. Each slice also has a gated write enable and a gated read enable that drive its storage array. The array and the data path are not part of this block.

A strap input picks the mode. In stand-alone mode every slice takes its own strobes, subject only to its full and empty state. The slice's expansion output then shows its half-full state. Its first-load/retransmit input rewinds its read address.

In chained mode the slices form a ring. The write right and the read right each move around the ring as a token. A slice pulses its expansion output in the cycle it uses its last location. The next slice in the ring takes the matching token at that clock edge, so the next strobe goes straight to the new holder without a lost cycle.

Top module: `xchain_ring`

## Requirements
- R1: While `rst` is high, all addresses and counts clear, so every slice reports `empty`=1 and `full`=0. In chained mode only the slice whose `fl_rt` bit is 1 during reset gets the write token and the read token. In stand-alone mode every slice holds both tokens.
- R2: In chained mode, `wr_en[i]` is 1 exactly when `wr_req[i]`=1, slice i holds the write token and slice i is not full. `rd_en[i]` follows the same rule with `rd_req`, the read token and not empty, and is further limited by R5.
- R3: In chained mode, a write accepted at address DEPTH-1 drives `xout[i]` high for that one cycle. From the next cycle slice (i+1) mod SLICES holds the write token and slice i does not. A write strobe in that next cycle is accepted by the new holder at address 0.
- R4: In chained mode, a read accepted at address DEPTH-1 drives `xout[i]` high for that one cycle and moves the read token to slice (i+1) mod SLICES in the same way.
- R5: In chained mode, when `wr_req[i]` and `rd_req[i]` are high in the same cycle, the write is accepted under R2 and the read is refused. A slice that sees its expansion input pulse takes the write token if its own `wr_req` is high, and otherwise takes the read token.
- R6: `wr_addr[i]` (bits i*AW upward) steps by one on each accepted write and wraps from DEPTH-1 to 0. `rd_addr[i]` does the same on each accepted read.
- R7: The occupancy count rises with each accepted write and falls with each accepted read. `empty`=1 when the count is 0 and `full`=1 when it is DEPTH. A write to a full slice is refused, and so is a read from an empty slice, in both modes.
- R8: In stand-alone mode, `xout[i]` is 1 exactly when slice i holds more than DEPTH/2 entries.
- R9: In stand-alone mode, tokens have no effect and every slice reports both tokens held. Each slice accepts its own write and read strobes independently, including both in the same cycle.
- R10: In stand-alone mode, `fl_rt[i]`=1 refuses both strobes of slice i in that cycle, sets `rd_addr[i]` to 0, and sets the count to the number of writes since reset, capped at DEPTH.
- R11: In chained mode, `fl_rt` has no effect after reset: addresses, counts and tokens continue unchanged.
- R12: In chained mode, exactly one slice holds the write token and exactly one holds the read token at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_mode | input | 1 | Strap: 1 = chained ring, 0 = stand-alone slices |
| wr_req | input | SLICES | Write strobe for each slice (shared value in chained mode) |
| rd_req | input | SLICES | Read strobe for each slice (shared value in chained mode) |
| fl_rt | input | SLICES | Chained: first-loaded marker sampled in reset; stand-alone: retransmit |
| wr_en | output | SLICES | Gated write enable to each slice array |
| rd_en | output | SLICES | Gated read enable to each slice array |
| wr_addr | output | SLICES*AW | Write address of each slice, slice i at bits i*AW |
| rd_addr | output | SLICES*AW | Read address of each slice, slice i at bits i*AW |
| empty | output | SLICES | Slice holds no entries |
| full | output | SLICES | Slice holds DEPTH entries |
| xout | output | SLICES | Chained: hand-off pulse; stand-alone: half-full |
| wtok | output | SLICES | Slice holds the write token |
| rtok | output | SLICES | Slice holds the read token |

## Verification
In chained mode a write strobe and a read strobe can arrive in the same cycle, and a token hand-off can also happen in that cycle on the single expansion line. The bench provokes this with runs of cycles that carry both strobes on all slices. Some of these runs start while the write holder is at its last location. Others are mixed with plain reads around the read holder's wrap. In each such cycle it checks that the read enable stays low, the write proceeds, and the write token, not the read token, lands in the next slice. A second overlap is a retransmit pulse in stand-alone mode that comes with both strobes active. It is judged by both enables being low and by the read address and count read back on the next cycle.

// File: rtl/xchain_pkg.sv
package xchain_pkg;

    typedef enum logic [1:0] {
        HK_NONE  = 2'd0,
        HK_WRITE = 2'd1,
        HK_READ  = 2'd2
    } hand_e;

    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic rt_go;
    } strobe_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } occ_t;

    function automatic int ring_next(input int idx, input int n);
        return (idx + 1) % n;
    endfunction

    function automatic int ring_prev(input int idx, input int n);
        return (idx + n - 1) % n;
    endfunction

    function automatic hand_e classify(input logic pulse, input logic wr_seen,
                                       input logic rd_seen);
        if (!pulse)  return HK_NONE;
        if (wr_seen) return HK_WRITE;
        if (rd_seen) return HK_READ;
        return HK_NONE;
    endfunction

endpackage

// File: rtl/xchain_gate.sv
module xchain_gate
    import xchain_pkg::*;
(
    input  logic    chain,
    input  logic    wr_req,
    input  logic    rd_req,
    input  logic    rt_req,
    input  logic    wtok,
    input  logic    rtok,
    input  occ_t    occ,
    input  logic    w_at_last,
    input  logic    r_at_last,
    output strobe_t go,
    output logic    send_w,
    output logic    send_r
);
    logic rt_go;
    logic wr_go;
    logic rd_go;

    always_comb begin
        rt_go = !chain && rt_req;
        wr_go = wr_req && wtok && !occ.full && !rt_go;
        // in chained mode a write owns the cycle; the read waits
        rd_go = rd_req && rtok && !occ.empty && !rt_go && !(chain && wr_req);
        go.wr_go = wr_go;
        go.rd_go = rd_go;
        go.rt_go = rt_go;
        send_w   = chain && wr_go && w_at_last;
        send_r   = chain && rd_go && r_at_last;
    end

endmodule

// File: rtl/xchain_ptrs.sv
module xchain_ptrs
    import xchain_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       go,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          w_at_last,
    output logic          r_at_last,
    output occ_t          occ
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALFV = (AW+1)'(DEPTH / 2);

    logic [AW:0] cnt;
    logic [AW:0] cnt_n;
    logic [AW:0] wsum;

    always_comb begin
        cnt_n = cnt;
        if (go.wr_go && !go.rd_go) cnt_n = cnt + 1'b1;
        if (go.rd_go && !go.wr_go) cnt_n = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr <= '0;
            raddr <= '0;
            cnt   <= '0;
            wsum  <= '0;
        end else if (go.rt_go) begin
            raddr <= '0;
            cnt   <= wsum;
        end else begin
            if (go.wr_go) begin
                waddr <= waddr + 1'b1;
                if (wsum != FULLV) wsum <= wsum + 1'b1;
            end
            if (go.rd_go) raddr <= raddr + 1'b1;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        w_at_last = (waddr == LAST);
        r_at_last = (raddr == LAST);
        occ.empty = (cnt == '0);
        occ.full  = (cnt == FULLV);
        occ.half  = (cnt > HALFV);
    end

endmodule

// File: rtl/xchain_token.sv
module xchain_token
    import xchain_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  chain,
    input  logic  first,
    input  logic  send_w,
    input  logic  send_r,
    input  hand_e hand_in,
    output logic  wtok,
    output logic  rtok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wtok <= chain ? first : 1'b1;
            rtok <= chain ? first : 1'b1;
        end else if (chain) begin
            wtok <= (wtok && !send_w) || (hand_in == HK_WRITE);
            rtok <= (rtok && !send_r) || (hand_in == HK_READ);
        end else begin
            wtok <= 1'b1;
            rtok <= 1'b1;
        end
    end

endmodule

// File: rtl/xchain_ring.sv
module xchain_ring
    import xchain_pkg::*;
#(
    parameter int SLICES = 4,
    parameter int AW     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chain_mode,
    input  logic [SLICES-1:0]    wr_req,
    input  logic [SLICES-1:0]    rd_req,
    input  logic [SLICES-1:0]    fl_rt,
    output logic [SLICES-1:0]    wr_en,
    output logic [SLICES-1:0]    rd_en,
    output logic [SLICES*AW-1:0] wr_addr,
    output logic [SLICES*AW-1:0] rd_addr,
    output logic [SLICES-1:0]    empty,
    output logic [SLICES-1:0]    full,
    output logic [SLICES-1:0]    xout,
    output logic [SLICES-1:0]    wtok,
    output logic [SLICES-1:0]    rtok
);
    logic [SLICES-1:0] pulse;

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        localparam int PV = ring_prev(i, SLICES);

        strobe_t go;
        occ_t    occ;
        logic    w_last;
        logic    r_last;
        logic    send_w;
        logic    send_r;
        logic    xin;
        hand_e   hand_in;

        assign xin     = chain_mode && pulse[PV];
        assign hand_in = classify(xin, wr_req[i], rd_req[i]);

        xchain_gate u_gate (
            .chain     (chain_mode),
            .wr_req    (wr_req[i]),
            .rd_req    (rd_req[i]),
            .rt_req    (fl_rt[i]),
            .wtok      (wtok[i]),
            .rtok      (rtok[i]),
            .occ       (occ),
            .w_at_last (w_last),
            .r_at_last (r_last),
            .go        (go),
            .send_w    (send_w),
            .send_r    (send_r)
        );

        xchain_ptrs #(.AW(AW)) u_ptrs (
            .clk       (clk),
            .rst       (rst),
            .go        (go),
            .waddr     (wr_addr[i*AW +: AW]),
            .raddr     (rd_addr[i*AW +: AW]),
            .w_at_last (w_last),
            .r_at_last (r_last),
            .occ       (occ)
        );

        xchain_token u_tok (
            .clk     (clk),
            .rst     (rst),
            .chain   (chain_mode),
            .first   (fl_rt[i]),
            .send_w  (send_w),
            .send_r  (send_r),
            .hand_in (hand_in),
            .wtok    (wtok[i]),
            .rtok    (rtok[i])
        );

        assign pulse[i] = send_w || send_r;
        assign xout[i]  = chain_mode ? pulse[i] : occ.half;
        assign wr_en[i] = go.wr_go;
        assign rd_en[i] = go.rd_go;
        assign empty[i] = occ.empty;
        assign full[i]  = occ.full;
    end

endmodule

// File: rtl/xchain_chk.sv
module xchain_chk #(
    parameter int SLICES = 4,
    parameter int AW     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 chain_mode,
    input logic [SLICES-1:0]    wr_req,
    input logic [SLICES-1:0]    rd_req,
    input logic [SLICES-1:0]    fl_rt,
    input logic [SLICES-1:0]    wr_en,
    input logic [SLICES-1:0]    rd_en,
    input logic [SLICES*AW-1:0] wr_addr,
    input logic [SLICES*AW-1:0] rd_addr,
    input logic [SLICES-1:0]    empty,
    input logic [SLICES-1:0]    full,
    input logic [SLICES-1:0]    xout,
    input logic [SLICES-1:0]    wtok,
    input logic [SLICES-1:0]    rtok
);
    AST_TOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        chain_mode |-> ($countones(wtok) == 1 && $countones(rtok) == 1)); // R12

    AST_SOLO_TOKENS: assert property (@(posedge clk) disable iff (rst)
        !chain_mode |-> (&wtok && &rtok)); // R9

    for (genvar i = 0; i < SLICES; i++) begin : g_chk
        localparam int NX = (i + 1) % SLICES;

        AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |-> !full[i]); // R7

        AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
            rd_en[i] |-> !empty[i]); // R7

        AST_WR_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (rst)
            (chain_mode && wr_en[i]) |-> wtok[i]); // R2

        AST_RD_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (rst)
            (chain_mode && rd_en[i]) |-> rtok[i]); // R2

        AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
            (chain_mode && rd_en[i]) |-> !wr_req[i]); // R5

        AST_PULSE_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
            (chain_mode && xout[i]) |-> (wr_en[i] ^ rd_en[i])); // R5

        AST_RETRANSMIT_REWIND: assert property (@(posedge clk) disable iff (rst)
            (!chain_mode && fl_rt[i]) |=> (rd_addr[i*AW +: AW] == '0)); // R10

        if (SLICES > 1) begin : g_pass
            AST_WTOK_PASSES: assert property (@(posedge clk) disable iff (rst)
                (chain_mode && wr_en[i] && xout[i]) |=> (wtok[NX] && !wtok[i])); // R3

            AST_RTOK_PASSES: assert property (@(posedge clk) disable iff (rst)
                (chain_mode && rd_en[i] && xout[i]) |=> (rtok[NX] && !rtok[i])); // R4
        end
    end

endmodule

bind xchain_ring xchain_chk #(.SLICES(SLICES), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chain_mode (chain_mode),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .fl_rt      (fl_rt),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .empty      (empty),
    .full       (full),
    .xout       (xout),
    .wtok       (wtok),
    .rtok       (rtok)
);

// File: tb/sim_xchain_ring.sv
module sim_xchain_ring;
    localparam int N   = 4;
    localparam int AW  = 3;
    localparam int D   = 1 << AW;
    localparam int PER = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           chain_mode = 1'b1;
    logic [N-1:0]   wr_req = '0;
    logic [N-1:0]   rd_req = '0;
    logic [N-1:0]   fl_rt  = 4'b0001;
    logic [N-1:0]   wr_en, rd_en, empty, full, xout, wtok, rtok;
    logic [N*AW-1:0] wr_addr, rd_addr;

    int nchk = 0;
    int nfail = 0;

    int cnt[N];
    int wa[N];
    int ra[N];
    int ws[N];
    int wt = 0;
    int rt = 0;
    bit mch = 1'b1;

    localparam logic [N-1:0] ALL = '1;
    localparam logic [N-1:0] NONE = '0;

    always #(PER/2) clk = ~clk;

    xchain_ring #(.SLICES(N), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .chain_mode(chain_mode),
        .wr_req(wr_req), .rd_req(rd_req), .fl_rt(fl_rt),
        .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .empty(empty), .full(full), .xout(xout), .wtok(wtok), .rtok(rtok)
    );

    task automatic chk(input bit ok, input string tg, input string what,
                       input int idx, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s slice %0d actual=%0d expected=%0d", tg, what, idx, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode, input logic [N-1:0] first);
        @(negedge clk);
        rst = 1'b1; chain_mode = mode; fl_rt = first; wr_req = '0; rd_req = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mch = mode;
        for (int i = 0; i < N; i++) begin
            cnt[i] = 0; wa[i] = 0; ra[i] = 0; ws[i] = 0;
            if (first[i]) begin wt = i; rt = i; end
        end
    endtask

    // one cycle: drive, compare every output with the model, then advance
    task automatic cyc(input logic [N-1:0] w, input logic [N-1:0] r,
                       input logic [N-1:0] f, input string tg);
        logic [N-1:0] ew, er, et, ex;
        int nwt, nrt;
        @(negedge clk);
        wr_req = w; rd_req = r; fl_rt = f;
        #1;
        for (int i = 0; i < N; i++) begin
            if (mch) begin
                et[i] = 1'b0;
                ew[i] = w[i] && (wt == i) && (cnt[i] < D);
                er[i] = r[i] && (rt == i) && (cnt[i] > 0) && !w[i];
                ex[i] = (ew[i] && wa[i] == D-1) || (er[i] && ra[i] == D-1);
            end else begin
                et[i] = f[i];
                ew[i] = w[i] && (cnt[i] < D) && !f[i];
                er[i] = r[i] && (cnt[i] > 0) && !f[i];
                ex[i] = cnt[i] > D/2;
            end
            chk(wr_en[i] == ew[i], tg, mch ? "R2 wr_en" : "R9 wr_en", i, wr_en[i], ew[i]);
            chk(rd_en[i] == er[i], tg, mch ? "R2 rd_en" : "R9 rd_en", i, rd_en[i], er[i]);
            chk(xout[i] == ex[i], tg, mch ? "R3 xout" : "R8 xout", i, xout[i], ex[i]);
            chk(int'(wr_addr[i*AW +: AW]) == wa[i], tg, "R6 wr_addr", i, wr_addr[i*AW +: AW], wa[i]);
            chk(int'(rd_addr[i*AW +: AW]) == ra[i], tg, "R6 rd_addr", i, rd_addr[i*AW +: AW], ra[i]);
            chk(empty[i] == (cnt[i] == 0), tg, "R7 empty", i, empty[i], cnt[i] == 0);
            chk(full[i] == (cnt[i] == D), tg, "R7 full", i, full[i], cnt[i] == D);
            chk(wtok[i] == (mch ? (wt == i) : 1'b1), tg, "R12 wtok", i, wtok[i], mch ? (wt == i) : 1);
            chk(rtok[i] == (mch ? (rt == i) : 1'b1), tg, "R12 rtok", i, rtok[i], mch ? (rt == i) : 1);
        end
        @(posedge clk);
        nwt = wt; nrt = rt;
        for (int i = 0; i < N; i++) begin
            if (et[i]) begin
                ra[i] = 0; cnt[i] = ws[i];
            end else begin
                if (ew[i]) begin
                    if (wa[i] == D-1) nwt = (i + 1) % N;
                    wa[i] = (wa[i] + 1) % D; cnt[i]++;
                    if (ws[i] < D) ws[i]++;
                end
                if (er[i]) begin
                    if (ra[i] == D-1) nrt = (i + 1) % N;
                    ra[i] = (ra[i] + 1) % D; cnt[i]--;
                end
            end
        end
        wt = nwt; rt = nrt;
    endtask

    task automatic t_reset_state;
        do_reset(1'b1, 4'b0001);
        cyc(NONE, NONE, 4'b0001, "R1 chained");
        do_reset(1'b0, NONE);
        cyc(NONE, NONE, NONE, "R1 solo");
    endtask

    task automatic t_chain_fill_drain;
        do_reset(1'b1, 4'b0001);
        for (int k = 0; k < N*D + 2; k++) cyc(ALL, NONE, 4'b0001, "R3 fill");
        for (int k = 0; k < N*D + 2; k++) cyc(NONE, ALL, 4'b0001, "R4 drain");
    endtask

    task automatic t_chain_wrap_start;
        do_reset(1'b1, 4'b0100);
        for (int k = 0; k < 20; k++) cyc(ALL, NONE, 4'b0100, "R3 ring wrap");
        for (int k = 0; k < 21; k++) cyc(NONE, ALL, 4'b0100, "R4 ring wrap");
    endtask

    task automatic t_chain_collide;
        do_reset(1'b1, 4'b0001);
        for (int k = 0; k < 5; k++) cyc(ALL, NONE, 4'b0001, "R5 prefill");
        for (int k = 0; k < 6; k++) cyc(ALL, ALL, 4'b0001, "R5 both strobes");
        for (int k = 0; k < 30; k++)
            cyc((k % 3 != 1) ? ALL : NONE, (k % 2 == 0) ? ALL : NONE, 4'b0001, "R5 mixed");
    endtask

    task automatic t_chain_no_rt;
        do_reset(1'b1, 4'b0001);
        for (int k = 0; k < 12; k++) cyc(ALL, NONE, 4'b0001, "R11 load");
        for (int k = 0; k < 3; k++) cyc(NONE, ALL, 4'b0001, "R11 read");
        cyc(NONE, NONE, 4'b1111, "R11 pulse");
        cyc(NONE, NONE, 4'b0110, "R11 pulse");
        for (int k = 0; k < 10; k++) cyc(NONE, ALL, 4'b0000, "R11 after");
    endtask

    task automatic t_solo;
        logic [N-1:0] w, r;
        do_reset(1'b0, NONE);
        for (int k = 0; k < 14; k++) begin
            w = 4'b1001 | ((k % 2 == 1) ? 4'b0010 : 4'b0000) | ((k < 6) ? 4'b0100 : 4'b0000);
            r = ((k >= 3) ? 4'b0010 : 4'b0000) | ((k >= 4) ? 4'b1000 : 4'b0000)
              | ((k >= 9) ? 4'b0100 : 4'b0000);
            cyc(w, r, NONE, "R9 independent");
        end
        for (int k = 0; k < 4; k++) cyc(NONE, 4'b0001, NONE, "R8 half");
    endtask

    task automatic t_solo_rt;
        do_reset(1'b0, NONE);
        for (int k = 0; k < 10; k++) cyc(4'b0111, NONE, NONE, "R10 load");
        for (int k = 0; k < 5; k++) cyc(NONE, ALL, NONE, "R10 read");
        cyc(NONE, NONE, 4'b0101, "R10 rewind");
        cyc(ALL, ALL, 4'b0010, "R10 strobes blocked");
        for (int k = 0; k < 9; k++) cyc(NONE, ALL, NONE, "R10 reread");
    endtask

    initial begin
        #(PER * 150000);
        nfail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_chain_fill_drain();
        t_chain_wrap_start();
        t_chain_collide();
        t_chain_no_rt();
        t_solo();
        t_solo_rt();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule